// File: doc/BRIEF.md
# Serial Configuration Loader Controller

This block takes configuration data from a four-wire serial link and turns it into accesses on a parallel configuration memory port. The link has a data-in line, a mode line, a clock and a data-out line. A three-state controller walks through idle, shift and execute. While in shift, it collects a 5-bit instruction. While in execute, it carries that instruction out.

The instructions load a combined data-and-address register and write it into one configuration column. They can also read a column back and send it out on the data-out line, clear the whole configuration memory, or load a separate register of per-cell architecture bits. The memory itself sits outside the block. The block gives it an address, write data, a write strobe and an erase strobe, and takes back combinational read data for the addressed column.

Top module: `serial_cfg_loader`

## Requirements
- R1: The controller visits three states in the fixed cycle idle, shift, execute, idle. It moves one step on each rising `tck` edge where `smode` is 1. After reset it is in idle.
- R2: On a rising edge where `smode` is 0 the state does not change. In idle nothing else changes either, so `sdi` activity there alters no register and raises no strobe.
- R3: In shift, each rising edge with `smode` 0 shifts `sdi` into a 5-bit instruction register, least significant bit first. Execute performs the last 5 bits shifted. The codes are: load data 0x02, erase 0x10, program 0x07, read-back 0x0A, load architecture 0x15.
- R4: Under load data, each rising edge in execute with `smode` 0 shifts `sdi` into a 138-bit data register. The first 132 bits shifted become column bits 0 to 131, and the last 6 bits become the column address, least significant bit first.
- R5: Under program, the first rising edge in execute raises `cfg_we` for exactly one cycle. At that point `cfg_addr` and `cfg_wdata` carry the address and column fields of the data register.
- R6: Under read-back, the first rising edge in execute copies `cfg_rdata` into the 132 column bits of the data register and keeps the address field. A following load data sequence returns those bits on `sdo` column bit 0 first, then the 6 address bits.
- R7: Under load architecture, each rising edge in execute with `smode` 0 shifts `sdi` into a 20-bit register (10 cells × 2 bits) driven on `arch_cfg`. The first bit shifted ends at bit 0.
- R8: Under erase, the first rising edge in execute raises `cfg_erase` for exactly one cycle. The memory then reads back as all ones.
- R9: `sdo` is updated on each falling `tck` edge with bit 0 of the data register.
- R10: An undefined instruction code raises no strobe and changes neither the data register nor the architecture register.
- R11: Reset clears the data, architecture and instruction registers and `sdo`. The cleared instruction code 0x00 is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial data in |
| smode | input | 1 | Mode line, 1 advances the state |
| sdo | output | 1 | Serial data out, falling-edge register |
| cfg_addr | output | 6 | Column address to the configuration memory |
| cfg_wdata | output | 132 | Column write data |
| cfg_we | output | 1 | Column write strobe |
| cfg_erase | output | 1 | Whole-memory erase strobe |
| cfg_rdata | input | 132 | Combinational read data of the addressed column |
| arch_cfg | output | 20 | Cell architecture bits |

## Verification
The memory strobes are combinational from registers that settle after the transition into execute. They are due in the cycle that ends with the first execute edge. The monitor samples them at the falling edge of that cycle and compares each write against the address and data the driver queued. The read-back capture lands on that same edge. Each `sdo` bit appears at the falling edge that follows the rising edge that placed it in bit 0, so the driver records `sdo` just after each falling edge and before the rising edge that shifts it away. Architecture bits and the register contents after an undefined instruction are checked once execute has been left.

// File: rtl/loader_pkg.sv
package loader_pkg;

   localparam int OPC_W = 5;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_EXEC  = 2'd2
   } ld_state_e;

   localparam logic [OPC_W-1:0] OP_LOAD_DATA = 5'h02;
   localparam logic [OPC_W-1:0] OP_ERASE     = 5'h10;
   localparam logic [OPC_W-1:0] OP_PROGRAM   = 5'h07;
   localparam logic [OPC_W-1:0] OP_READBACK  = 5'h0A;
   localparam logic [OPC_W-1:0] OP_LOAD_ARCH = 5'h15;

endpackage

// File: rtl/loader_fsm.sv
module loader_fsm
   import loader_pkg::*;
(
   input  logic      tck,
   input  logic      rst_n,
   input  logic      smode,
   output ld_state_e state,
   output logic      first_exec
);

   ld_state_e state_q, state_d;
   logic      first_q;

   always_comb begin
      state_d = state_q;
      if (smode) begin
         unique case (state_q)
            ST_IDLE:  state_d = ST_SHIFT;
            ST_SHIFT: state_d = ST_EXEC;
            ST_EXEC:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         first_q <= 1'b0;
      end else begin
         state_q <= state_d;
         first_q <= (state_q == ST_SHIFT) && smode;
      end
   end

   assign state      = state_q;
   assign first_exec = first_q;

   // R2: a zero mode sample keeps the state
   p_hold_state_r2: assert property (@(posedge tck) disable iff (!rst_n)
      !smode |=> $stable(state_q));

   // R1: a one mode sample always moves the state
   p_advance_r1: assert property (@(posedge tck) disable iff (!rst_n)
      smode |=> (state_q != $past(state_q)));

   // R1: the one-shot flag is only seen in execute
   p_first_in_exec_r1: assert property (@(posedge tck) disable iff (!rst_n)
      first_q |-> (state_q == ST_EXEC));

endmodule

// File: rtl/loader_shreg.sv
module loader_shreg #(
   parameter int W = 8
) (
   input  logic         tck,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         sin,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] q
);

   if (W < 2) begin : g_bad_width
      $error("loader_shreg: W must be at least 2");
   end

   logic [W-1:0] q_r;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)        q_r <= '0;
      else if (load_en)  q_r <= load_val;
      else if (shift_en) q_r <= {sin, q_r[W-1:1]};
   end

   assign q = q_r;

   p_idle_hold_r2: assert property (@(posedge tck) disable iff (!rst_n)
      (!shift_en && !load_en) |=> $stable(q_r));

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
   import loader_pkg::*;
#(
   parameter int COL_BITS      = 132,
   parameter int ADDR_W        = 6,
   parameter int CELLS         = 10,
   parameter int BITS_PER_CELL = 2,
   parameter bit SDO_ON_FALL   = 1'b1
) (
   input  logic                         tck,
   input  logic                         rst_n,
   input  logic                         sdi,
   input  logic                         smode,
   output logic                         sdo,
   output logic [ADDR_W-1:0]            cfg_addr,
   output logic [COL_BITS-1:0]          cfg_wdata,
   output logic                         cfg_we,
   output logic                         cfg_erase,
   input  logic [COL_BITS-1:0]          cfg_rdata,
   output logic [CELLS*BITS_PER_CELL-1:0] arch_cfg
);

   localparam int DR_W = COL_BITS + ADDR_W;
   localparam int AR_W = CELLS * BITS_PER_CELL;

   if (COL_BITS < 1 || ADDR_W < 1 || AR_W < 2) begin : g_bad_params
      $error("serial_cfg_loader: column, address and architecture widths must be positive");
   end

   ld_state_e        state;
   logic             first_exec;
   logic [OPC_W-1:0] ir_q;
   logic [DR_W-1:0]  dr_q;
   logic [AR_W-1:0]  ar_q;
   logic             in_exec, exec_shift;
   logic             ir_shift, dr_shift, dr_load, ar_shift;

   loader_fsm u_fsm (
      .tck        (tck),
      .rst_n      (rst_n),
      .smode      (smode),
      .state      (state),
      .first_exec (first_exec)
   );

   assign in_exec    = (state == ST_EXEC);
   assign exec_shift = in_exec && !smode;
   assign ir_shift   = (state == ST_SHIFT) && !smode;
   assign dr_load    = in_exec && first_exec && (ir_q == OP_READBACK);
   assign dr_shift   = exec_shift && ((ir_q == OP_LOAD_DATA) ||
                                      ((ir_q == OP_READBACK) && !first_exec));
   assign ar_shift   = exec_shift && (ir_q == OP_LOAD_ARCH);

   loader_shreg #(.W(OPC_W)) u_ir (
      .tck      (tck),
      .rst_n    (rst_n),
      .shift_en (ir_shift),
      .sin      (sdi),
      .load_en  (1'b0),
      .load_val ({OPC_W{1'b0}}),
      .q        (ir_q)
   );

   loader_shreg #(.W(DR_W)) u_dr (
      .tck      (tck),
      .rst_n    (rst_n),
      .shift_en (dr_shift),
      .sin      (sdi),
      .load_en  (dr_load),
      .load_val ({dr_q[DR_W-1:COL_BITS], cfg_rdata}),
      .q        (dr_q)
   );

   loader_shreg #(.W(AR_W)) u_ar (
      .tck      (tck),
      .rst_n    (rst_n),
      .shift_en (ar_shift),
      .sin      (sdi),
      .load_en  (1'b0),
      .load_val ({AR_W{1'b0}}),
      .q        (ar_q)
   );

   assign cfg_addr  = dr_q[DR_W-1:COL_BITS];
   assign cfg_wdata = dr_q[COL_BITS-1:0];
   assign cfg_we    = in_exec && first_exec && (ir_q == OP_PROGRAM);
   assign cfg_erase = in_exec && first_exec && (ir_q == OP_ERASE);
   assign arch_cfg  = ar_q;

   logic sdo_q;
   if (SDO_ON_FALL) begin : g_sdo_fall
      always_ff @(negedge tck or negedge rst_n) begin
         if (!rst_n) sdo_q <= 1'b0;
         else        sdo_q <= dr_q[0];
      end
   end else begin : g_sdo_rise
      always_ff @(posedge tck or negedge rst_n) begin
         if (!rst_n) sdo_q <= 1'b0;
         else        sdo_q <= dr_q[0];
      end
   end
   assign sdo = sdo_q;

   // R5: one write per execute visit
   p_single_write_r5: assert property (@(posedge tck) disable iff (!rst_n)
      cfg_we |=> !cfg_we);

   // R8: one erase per execute visit
   p_single_erase_r8: assert property (@(posedge tck) disable iff (!rst_n)
      cfg_erase |=> !cfg_erase);

   // R3: the instruction only moves in the shift state
   p_ir_frozen_r3: assert property (@(posedge tck) disable iff (!rst_n)
      (state != ST_SHIFT) |=> $stable(ir_q));

   // R7: architecture bits only move under their own instruction
   p_arch_hold_r7: assert property (@(posedge tck) disable iff (!rst_n)
      (ir_q != OP_LOAD_ARCH) |=> $stable(ar_q));

   // R4: the data register only moves in execute
   p_dr_hold_r4: assert property (@(posedge tck) disable iff (!rst_n)
      !in_exec |=> $stable(dr_q));

endmodule

// File: tb/serial_cfg_loader_tb.sv
`timescale 1ns/1ps
module serial_cfg_loader_tb;

   localparam int COLB = 132;
   localparam int AW   = 6;
   localparam int ARW  = 20;
   localparam int DRW  = COLB + AW;

   logic            tck = 1'b0;
   logic            rst_n = 1'b0;
   logic            sdi = 1'b0;
   logic            smode = 1'b0;
   logic            sdo;
   logic [AW-1:0]   cfg_addr;
   logic [COLB-1:0] cfg_wdata;
   logic            cfg_we, cfg_erase;
   logic [COLB-1:0] cfg_rdata;
   logic [ARW-1:0]  arch_cfg;

   always #2.5 tck = ~tck;

   serial_cfg_loader u_dut (
      .tck(tck), .rst_n(rst_n), .sdi(sdi), .smode(smode), .sdo(sdo),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we),
      .cfg_erase(cfg_erase), .cfg_rdata(cfg_rdata), .arch_cfg(arch_cfg)
   );

   logic [COLB-1:0] mem [64];
   assign cfg_rdata = mem[cfg_addr];
   initial for (int i = 0; i < 64; i++) mem[i] = '0;
   always @(posedge tck) begin
      if (cfg_erase) for (int i = 0; i < 64; i++) mem[i] <= '1;
      else if (cfg_we) mem[cfg_addr] <= cfg_wdata;
   end

   int n_chk = 0, n_fail = 0;
   int erase_seen = 0;
   logic last_sdo;

   typedef struct packed { logic [AW-1:0] a; logic [COLB-1:0] d; } wr_t;
   wr_t exp_q[$];

   task automatic chk(string req, logic [DRW-1:0] act, logic [DRW-1:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: compares strobes with the queued expectations
   always @(negedge tck) begin
      if (rst_n && cfg_erase) erase_seen++;
      if (rst_n && cfg_we) begin
         if (exp_q.size() == 0) begin
            chk("R5", {cfg_addr, cfg_wdata}, '0, "unexpected write");
         end else begin
            wr_t e;
            e = exp_q.pop_front();
            chk("R5", {cfg_addr, cfg_wdata}, {e.a, e.d}, "write addr+data");
         end
      end
   end

   task automatic step(input logic m, input logic d);
      @(negedge tck); #1;
      last_sdo = sdo;
      smode = m; sdi = d;
      @(posedge tck); #1;
   endtask

   task automatic enter_exec(input logic [4:0] op);
      step(1'b1, 1'b0);
      for (int i = 0; i < 5; i++) step(1'b0, op[i]);
      step(1'b1, 1'b0);
   endtask

   task automatic one_shot(input logic [4:0] op);
      enter_exec(op);
      step(1'b1, 1'b0);
   endtask

   task automatic shift_dr(input logic [COLB-1:0] d, input logic [AW-1:0] a,
                           output logic [DRW-1:0] got);
      logic [DRW-1:0] v;
      v = {a, d};
      enter_exec(5'h02);
      for (int i = 0; i < DRW; i++) begin
         step(1'b0, v[i]);
         got[i] = last_sdo;
      end
      step(1'b1, 1'b0);
   endtask

   task automatic program_col(input logic [COLB-1:0] d, input logic [AW-1:0] a);
      logic [DRW-1:0] junk;
      shift_dr(d, a, junk);
      exp_q.push_back({a, d});
      one_shot(5'h07);
   endtask

   task automatic read_col(input logic [AW-1:0] a, output logic [DRW-1:0] got);
      logic [DRW-1:0] junk;
      shift_dr({COLB{1'b0}}, a, junk);
      one_shot(5'h0A);
      shift_dr({COLB{1'b0}}, '0, got);
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [DRW-1:0] got;
      logic [COLB-1:0] pa, pb, pc;
      logic [ARW-1:0] arch_pat, arch_before;
      int e0;

      pa = {33{4'hA}} ^ {4'h1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210};
      pb = {66{2'b01}} ^ {4'h8, 128'hDEAD_BEEF_0000_FFFF_1234_8765_AAAA_5555};
      pc = {4'h3, 128'hC0FF_EE00_1111_2222_3333_4444_5555_6666};
      arch_pat = 20'hA5C3E;

      repeat (3) @(posedge tck);
      #1;
      // R11: reset state
      chk("R11", {132'b0, sdo, cfg_we, cfg_erase, 3'b0}, '0, "outputs in reset");
      @(negedge tck); rst_n = 1'b1;
      @(posedge tck); #1;
      chk("R11", {118'b0, arch_cfg}, '0, "architecture after reset");
      chk("R11", {cfg_addr, cfg_wdata}, '0, "data register after reset");

      // R2: idle activity with mode 0 changes nothing
      for (int i = 0; i < 12; i++) step(1'b0, i[0]);
      chk("R2", {118'b0, arch_cfg}, '0, "arch after idle toggling");
      chk("R2", {cfg_addr, cfg_wdata}, '0, "data reg after idle toggling");
      chk("R2", {137'b0, cfg_we | cfg_erase}, '0, "strobes in idle");

      // R8: erase then read back an untouched column
      e0 = erase_seen;
      one_shot(5'h10);
      chk("R8", DRW'(erase_seen - e0), DRW'(1), "erase pulse count");
      read_col(6'd9, got);
      chk("R8", {6'b0, got[COLB-1:0]}, {6'b0, {COLB{1'b1}}}, "column after erase");
      chk("R6", {132'b0, got[DRW-1:COLB]}, {132'b0, 6'd9}, "address kept through read-back");

      // R4 R5: program two columns (monitor checks writes)
      program_col(pa, 6'd3);
      program_col(pb, 6'd43);
      chk("R5", DRW'(exp_q.size()), '0, "all expected writes seen");

      // R6 R9: read them back through sdo
      read_col(6'd3, got);
      chk("R6", {6'b0, got[COLB-1:0]}, {6'b0, pa}, "read-back column 3");
      read_col(6'd43, got);
      chk("R6", {6'b0, got[COLB-1:0]}, {6'b0, pb}, "read-back column 43");
      chk("R9", {132'b0, got[DRW-1:COLB]}, {132'b0, 6'd43}, "address bits after data on sdo");

      // R7: architecture bits, first shifted at bit 0
      enter_exec(5'h15);
      for (int i = 0; i < ARW; i++) step(1'b0, arch_pat[i]);
      step(1'b1, 1'b0);
      chk("R7", {118'b0, arch_cfg}, {118'b0, arch_pat}, "architecture register");

      // R10 R3: undefined codes (0x1F, and 0x01 which is erase bit-reversed)
      shift_dr(pc, 6'd7, got);
      arch_before = arch_cfg;
      e0 = erase_seen;
      one_shot(5'h1F);
      one_shot(5'h01);
      chk("R3", DRW'(erase_seen - e0), '0, "no erase from reversed code");
      chk("R10", {118'b0, arch_cfg}, {118'b0, arch_before}, "arch after undefined");
      shift_dr('0, '0, got);
      chk("R10", got, {6'd7, pc}, "data reg after undefined");
      chk("R10", DRW'(exp_q.size()), '0, "no pending writes");

      // R1: full cycle returns to idle; a further program works
      program_col(pc, 6'd7);
      read_col(6'd7, got);
      chk("R1", {6'b0, got[COLB-1:0]}, {6'b0, pc}, "state cycle sequencing");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule